// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This peripheral guards a processor against a hung program. Software writes a control word to arm it. A prescaler then produces slow ticks, and a tick counter walks through two consecutive windows. When the first window runs out, the block raises a pre-timeout interrupt so that software still has a chance to react. When the second window also runs out, the block fires a one-cycle pulse on one of three reset request lines, which the mode field selects. The block then returns to its disarmed idle state.

Software keeps the timer from expiring by writing the restart bit. That write returns the count to the start of the first window, whichever window is running at the time. Each window is sized by its own 5-bit field, which holds the tick count minus one. The tick is 2^(BASE_EXP+scale) bus clocks long, with a 2-bit scale field. Once the first window has expired, clearing the arm bit no longer stops the countdown. The register port is a plain single-cycle write strobe with a combinational read path.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the control register reads 0x0000_0001 (disarmed, mode 1) and the flag register reads zero. `irq_pre` and all three reset outputs are low.
- R2: The control register at byte offset 0x8 holds the following fields and reads back exactly what was written to them: arm at bit 31, scale at bits 30:29, first-window length at bits 26:22, second-window length at bits 19:15 and mode at bits 1:0. All other bits read as zero. The restart register at offset 0x0 always reads zero.
- R3: One tick lasts 2^(BASE_EXP+scale) clock cycles, for every scale value from 0 to 3.
- R4: Once armed, or after a restart, the first window expires after (first-window length + 1) ticks. Its expiry sets flag bit 31 of offset 0x4, and `irq_pre` follows that flag.
- R5: The second window starts as the first one ends and expires after (second-window length + 1) ticks. Its expiry sets flag bit 30 and produces a single-cycle pulse on `rst_chip` (mode 0), `rst_cpu` (mode 1) or `rst_soft` (mode 2), or on no output (mode 3). It also clears the arm bit and returns the block to first-window idle.
- R6: While the block is disarmed in the first window, the count is held at zero. Arming again starts a full first window.
- R7: Clearing the arm bit during the second window does not stop the countdown or the reset pulse.
- R8: Writing offset 0x0 with bit 31 set restarts the count at the start of the first window, from either window, and leaves the flags untouched. A write there with bit 31 clear has no effect.
- R9: Writing 1 to a flag bit at offset 0x4 clears it, and writing 0 leaves it unchanged. If an expiry sets a flag in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_pre | output | 1 | Pre-timeout interrupt, high while flag bit 31 is set |
| rst_chip | output | 1 | Whole-chip reset request pulse |
| rst_cpu | output | 1 | Processor-only reset request pulse |
| rst_soft | output | 1 | Software reset request pulse |

## Verification
The assertions assume that the scale and window fields stay constant while a countdown is running, so that a prescaler count can never skip past a shortened tick boundary. The stimulus rewrites these fields only while the block is disarmed in the first window, or writes back the values it already holds. The checks also assume that each write lasts one cycle and targets a single offset. The bench drives writes only through a task that holds the strobe for exactly one cycle, with one exception: the set-versus-clear case, which deliberately repeats the same flag-clear write for several cycles.

// File: rtl/wdog_twostage_pkg.sv
package wdog_twostage_pkg;

  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_KICK = 4'h0;
  localparam logic [REG_AW-1:0] OFS_FLAG = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h8;

  localparam int KICK_BIT = 31;
  localparam int F1_BIT   = 31;
  localparam int F2_BIT   = 30;
  localparam int EN_BIT   = 31;
  localparam int PRE_LSB  = 29;
  localparam int PH1_LSB  = 22;
  localparam int PH2_LSB  = 15;
  localparam int MODE_LSB = 0;

  localparam int PRE_W  = 2;
  localparam int PH_W   = 5;
  localparam int MODE_W = 2;
  localparam int N_RST  = 3;

  typedef enum logic [MODE_W-1:0] {
    RM_CHIP = 2'd0,
    RM_CPU  = 2'd1,
    RM_SOFT = 2'd2,
    RM_NONE = 2'd3
  } rst_mode_e;

  typedef struct packed {
    logic              en;
    logic [PRE_W-1:0]  pre;
    logic [PH_W-1:0]   ph1;
    logic [PH_W-1:0]   ph2;
    logic [MODE_W-1:0] mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, pre: '0, ph1: '0, ph2: '0, mode: RM_CPU};

  function automatic logic [REG_DW-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_DW-1:0] v;
    v = '0;
    v[EN_BIT]                = c.en;
    v[PRE_LSB  +: PRE_W]     = c.pre;
    v[PH1_LSB  +: PH_W]      = c.ph1;
    v[PH2_LSB  +: PH_W]      = c.ph2;
    v[MODE_LSB +: MODE_W]    = c.mode;
    return v;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_DW-1:0] d);
    ctrl_t c;
    c.en   = d[EN_BIT];
    c.pre  = d[PRE_LSB  +: PRE_W];
    c.ph1  = d[PH1_LSB  +: PH_W];
    c.ph2  = d[PH2_LSB  +: PH_W];
    c.mode = d[MODE_LSB +: MODE_W];
    return c;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_twostage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              set_f1,
  input  logic              set_f2,
  input  logic              expire_disarm,
  output ctrl_t             ctrl_q,
  output logic              flag1_q,
  output logic              flag2_q,
  output logic              kick
);

  logic  wr_ctrl, wr_flag;
  ctrl_t ctrl_nx;

  assign wr_ctrl = wr_en && (addr == OFS_CTRL);
  assign wr_flag = wr_en && (addr == OFS_FLAG);
  assign kick    = wr_en && (addr == OFS_KICK) && wdata[KICK_BIT];

  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr_ctrl) ctrl_nx = ctrl_unpack(wdata);
    if (expire_disarm) ctrl_nx.en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nx;
      flag1_q <= (flag1_q && !(wr_flag && wdata[F1_BIT])) || set_f1;
      flag2_q <= (flag2_q && !(wr_flag && wdata[F2_BIT])) || set_f2;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL: rdata = ctrl_pack(ctrl_q);
      OFS_FLAG: begin
        rdata[F1_BIT] = flag1_q;
        rdata[F2_BIT] = flag2_q;
      end
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int BASE_EXP = 25,
  parameter int PRE_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  localparam int N_SCALE = 1 << PRE_W;
  localparam int CW      = BASE_EXP + N_SCALE - 1;

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] last_count(input logic [PRE_W-1:0] p);
    int sh;
    sh = (N_SCALE - 1) - int'(p);
    return {CW{1'b1}} >> sh;
  endfunction

  assign tick = run && !restart && (cnt_q == last_count(pre));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_phase_seq.sv
module wdog_phase_seq #(
  parameter int PH_W   = 5,
  parameter int MODE_W = 2,
  parameter int N_RST  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              kick,
  input  logic              tick,
  input  logic [PH_W-1:0]   ph1,
  input  logic [PH_W-1:0]   ph2,
  input  logic [MODE_W-1:0] mode,
  output logic              run,
  output logic              in_p2,
  output logic              p1_expire,
  output logic              p2_expire,
  output logic [N_RST-1:0]  rst_pulse
);

  logic [PH_W-1:0] tcnt_q;
  logic            in_p2_q;

  function automatic logic window_done(input logic [PH_W-1:0] cnt,
                                       input logic [PH_W-1:0] lim);
    return cnt == lim;
  endfunction

  assign in_p2     = in_p2_q;
  assign run       = en || in_p2_q;
  assign p1_expire = run && tick && !kick && !in_p2_q && window_done(tcnt_q, ph1);
  assign p2_expire = run && tick && !kick &&  in_p2_q && window_done(tcnt_q, ph2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      in_p2_q <= 1'b0;
    end else if (kick || !run) begin
      tcnt_q  <= '0;
      in_p2_q <= 1'b0;
    end else if (p1_expire) begin
      tcnt_q  <= '0;
      in_p2_q <= 1'b1;
    end else if (p2_expire) begin
      tcnt_q  <= '0;
      in_p2_q <= 1'b0;
    end else if (tick) begin
      tcnt_q  <= tcnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_RST; k++) begin : g_rst
    always_ff @(posedge clk) begin
      if (!rst_n) rst_pulse[k] <= 1'b0;
      else        rst_pulse[k] <= p2_expire && (mode == MODE_W'(k));
    end
  end

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_twostage_pkg::*;
#(
  parameter int BASE_EXP = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic              irq_pre,
  output logic              rst_chip,
  output logic              rst_cpu,
  output logic              rst_soft
);

  ctrl_t            ctrl_q;
  logic             flag1_q, flag2_q;
  logic             kick, tick, run, in_p2;
  logic             p1_expire, p2_expire;
  logic             ctrl_en;
  logic [N_RST-1:0] rst_pulse;

  assign ctrl_en = ctrl_q.en;

  wdog_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .rdata         (rdata),
    .set_f1        (p1_expire),
    .set_f2        (p2_expire),
    .expire_disarm (p2_expire),
    .ctrl_q        (ctrl_q),
    .flag1_q       (flag1_q),
    .flag2_q       (flag2_q),
    .kick          (kick)
  );

  wdog_tick_gen #(
    .BASE_EXP (BASE_EXP),
    .PRE_W    (PRE_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (kick),
    .pre     (ctrl_q.pre),
    .tick    (tick)
  );

  wdog_phase_seq #(
    .PH_W   (PH_W),
    .MODE_W (MODE_W),
    .N_RST  (N_RST)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .kick      (kick),
    .tick      (tick),
    .ph1       (ctrl_q.ph1),
    .ph2       (ctrl_q.ph2),
    .mode      (ctrl_q.mode),
    .run       (run),
    .in_p2     (in_p2),
    .p1_expire (p1_expire),
    .p2_expire (p2_expire),
    .rst_pulse (rst_pulse)
  );

  assign irq_pre  = flag1_q;
  assign rst_chip = rst_pulse[RM_CHIP];
  assign rst_cpu  = rst_pulse[RM_CPU];
  assign rst_soft = rst_pulse[RM_SOFT];

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
  import wdog_twostage_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [REG_DW-1:0] wdata,
  input logic              irq_pre,
  input logic              rst_chip,
  input logic              rst_cpu,
  input logic              rst_soft,
  input logic              tick,
  input logic              run,
  input logic              kick,
  input logic              en,
  input logic              in_p2,
  input logic              p1_expire,
  input logic              p2_expire
);

  logic any_rst, f1_clear_wr;
  assign any_rst     = rst_chip || rst_cpu || rst_soft;
  assign f1_clear_wr = wr_en && (addr == OFS_FLAG) && wdata[F1_BIT];

  p_rst_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_chip, rst_cpu, rst_soft}));

  p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> !any_rst);

  p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |-> $past(p2_expire));

  p_expire_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    p2_expire |=> (!en && !in_p2));

  p_irq_on_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    p1_expire |=> (irq_pre && in_p2));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  p_no_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_p2 && !kick && !p2_expire) |=> in_p2);

  p_kick_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!in_p2 && irq_pre == $past(irq_pre)));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pre && !f1_clear_wr) |=> irq_pre);

endmodule

bind wdog_twostage wdog_twostage_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .irq_pre   (irq_pre),
  .rst_chip  (rst_chip),
  .rst_cpu   (rst_cpu),
  .rst_soft  (rst_soft),
  .tick      (tick),
  .run       (run),
  .kick      (kick),
  .en        (ctrl_en),
  .in_p2     (in_p2),
  .p1_expire (p1_expire),
  .p2_expire (p2_expire)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_BASE    = 2;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_pre, rst_chip, rst_cpu, rst_soft;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_twostage #(.BASE_EXP(TB_BASE)) u_wdog_twostage (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq_pre  (irq_pre),
    .rst_chip (rst_chip),
    .rst_cpu  (rst_cpu),
    .rst_soft (rst_soft)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    done = 0;

  // behavioural reference: elapsed running cycles against a cycle budget
  bit m_en, m_p2, m_f1, m_f2, m_rc, m_rp, m_rs;
  int m_pre, m_ph1, m_ph2, m_mode, m_el;

  always @(posedge clk) begin : ref_model
    bit kick_w, run, set1, set2, disarm;
    int budget;
    started = 1;
    if (!rst_n) begin
      m_en = 0; m_p2 = 0; m_f1 = 0; m_f2 = 0;
      m_rc = 0; m_rp = 0; m_rs = 0;
      m_pre = 0; m_ph1 = 0; m_ph2 = 0; m_mode = 1; m_el = 0;
    end else begin
      kick_w = wr_en && addr == 4'h0 && wdata[31];
      run = m_en || m_p2;
      set1 = 0; set2 = 0; disarm = 0;
      m_rc = 0; m_rp = 0; m_rs = 0;
      if (kick_w) begin
        m_p2 = 0; m_el = 0;
      end else if (run) begin
        m_el++;
        budget = ((m_p2 ? m_ph2 : m_ph1) + 1) * (1 << (TB_BASE + m_pre));
        if (m_el == budget) begin
          m_el = 0;
          if (!m_p2) begin
            m_p2 = 1; set1 = 1;
          end else begin
            m_p2 = 0; set2 = 1; disarm = 1;
            if (m_mode == 0) m_rc = 1;
            if (m_mode == 1) m_rp = 1;
            if (m_mode == 2) m_rs = 1;
          end
        end
      end else begin
        m_el = 0;
      end
      if (wr_en && addr == 4'h4) begin
        if (wdata[31]) m_f1 = 0;
        if (wdata[30]) m_f2 = 0;
      end
      if (set1) m_f1 = 1;
      if (set2) m_f2 = 1;
      if (wr_en && addr == 4'h8) begin
        m_en = wdata[31]; m_pre = int'(wdata[30:29]);
        m_ph1 = int'(wdata[26:22]); m_ph2 = int'(wdata[19:15]);
        m_mode = int'(wdata[1:0]);
      end
      if (disarm) m_en = 0;
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 4'h8) begin
      v[31] = m_en; v[30:29] = m_pre[1:0]; v[26:22] = m_ph1[4:0];
      v[19:15] = m_ph2[4:0]; v[1:0] = m_mode[1:0];
    end else if (a == 4'h4) begin
      v[31] = m_f1; v[30] = m_f2;
    end
    return v;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      cmp(cur_req, "irq_pre", 32'(irq_pre), 32'(m_f1));
      cmp(cur_req, "reset outputs", {29'd0, rst_chip, rst_cpu, rst_soft},
          {29'd0, m_rc, m_rp, m_rs});
      cmp(cur_req, "rdata", rdata, model_read(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    @(negedge clk);
    cmp(req, "register read", rdata, exp);
    @(posedge clk); #1;
  endtask

  // k = 0 is the first falling edge after the call
  task automatic wait_for(input int sel, input int limit, output int k);
    logic s;
    k = 0;
    forever begin
      @(negedge clk);
      case (sel)
        0: s = rst_chip;
        1: s = rst_cpu;
        2: s = rst_soft;
        default: s = irq_pre;
      endcase
      if (s || k >= limit) break;
      k++;
    end
  endtask

  function automatic logic [31:0] cfg(input bit en, input int pre, input int p1,
                                      input int p2, input int mode);
    return {en, pre[1:0], 2'b00, p1[4:0], 2'b00, p2[4:0], 13'd0, mode[1:0]};
  endfunction

  task automatic run_full(input string req, input int pre, input int p1,
                          input int p2, input int mode);
    int k, tl;
    tl = 1 << (TB_BASE + pre);
    cur_req = req;
    addr = 4'h4;
    wr(4'h8, cfg(1, pre, p1, p2, mode));
    wait_for(3, 5000, k);
    cmp("R4", "cycles to first expiry", k, (p1 + 1) * tl);
    if (mode < 3) begin
      wait_for(mode, 5000, k);
      cmp("R5", "cycles to reset pulse", k, (p2 + 1) * tl - 1);
      @(posedge clk); #1;
    end else begin
      wait_cyc((p2 + 1) * tl + 2);
    end
    expect_rd("R5", 4'h8, cfg(0, pre, p1, p2, mode));
    expect_rd("R5", 4'h4, 32'hC000_0000);
    wr(4'h4, 32'hC000_0000);
  endtask

  initial begin : stim
    int k;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    cur_req = "R1";
    expect_rd("R1", 4'h8, 32'h0000_0001);
    expect_rd("R1", 4'h4, 32'h0000_0000);

    // R2 field layout and read-as-zero bits
    cur_req = "R2";
    wr(4'h8, 32'h7FFF_FFFF);
    expect_rd("R2", 4'h8, 32'h67CF_8003);
    expect_rd("R2", 4'h0, 32'h0000_0000);
    wr(4'h8, 32'h0000_0001);

    // R3 R4 R5 each scale value and each mode
    run_full("R3", 0, 2, 1, 0);
    run_full("R3", 1, 0, 0, 1);
    run_full("R3", 2, 1, 0, 2);
    run_full("R5", 3, 0, 1, 3);
    run_full("R4", 0, 31, 0, 1);

    // R9 write-one-to-clear, write zero ignored
    cur_req = "R9";
    run_full("R9", 0, 0, 0, 3);
    wr(4'h8, cfg(0, 0, 0, 0, 3));
    wait_cyc(1);
    wr(4'h4, 32'h0000_0000);
    wr(4'h8, cfg(1, 0, 0, 0, 3));
    wait_cyc(12);
    expect_rd("R9", 4'h4, 32'hC000_0000);
    wr(4'h4, 32'h0000_0000);
    expect_rd("R9", 4'h4, 32'hC000_0000);
    wr(4'h4, 32'h4000_0000);
    expect_rd("R9", 4'h4, 32'h8000_0000);
    wr(4'h4, 32'h8000_0000);
    expect_rd("R9", 4'h4, 32'h0000_0000);

    // R9 set wins over a clear in the same cycle
    wr(4'h8, cfg(1, 0, 0, 0, 3));
    wr_en = 1'b1; addr = 4'h4; wdata = 32'h8000_0000;
    wait_cyc(8);
    wr_en = 1'b0;
    wait_cyc(4);
    wr(4'h4, 32'hC000_0000);

    // R6 disarm during the first window holds the count
    cur_req = "R6";
    wr(4'h8, cfg(1, 0, 3, 0, 1));
    wait_cyc(10);
    wr(4'h8, cfg(0, 0, 3, 0, 1));
    wait_cyc(40);
    cmp("R6", "irq while disarmed", 32'(irq_pre), 32'd0);
    addr = 4'h4;
    wr(4'h8, cfg(1, 0, 3, 0, 1));
    wait_for(3, 5000, k);
    cmp("R6", "full window after re-arm", k, 16);
    wait_for(1, 5000, k);
    cmp("R6", "reset after re-arm", k, 3);
    wait_cyc(2);
    wr(4'h4, 32'hC000_0000);

    // R7 disarm in the second window does not stop it
    cur_req = "R7";
    wr(4'h8, cfg(1, 0, 0, 7, 0));
    wait_for(3, 5000, k);
    @(posedge clk); #1;
    wr(4'h8, cfg(0, 0, 0, 7, 0));
    wait_for(0, 200, k);
    cmp("R7", "pulse still arrives", 32'(k < 200), 32'd1);
    wait_cyc(2);
    wr(4'h4, 32'hC000_0000);

    // R8 restart bit, in either window
    cur_req = "R8";
    wr(4'h8, cfg(1, 0, 1, 3, 1));
    wait_cyc(3);
    wr(4'h0, 32'h7FFF_FFFF);
    addr = 4'h4;
    wait_for(3, 5000, k);
    cmp("R8", "write without restart bit ignored", k, 4);
    wait_cyc(4);
    wr(4'h0, 32'h8000_0000);
    expect_rd("R8", 4'h4, 32'h8000_0000);
    wait_cyc(5);
    wr(4'h0, 32'h8000_0000);
    wait_for(1, 5000, k);
    cmp("R8", "restart from window one", k, 24);
    wait_cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    done = 1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule